// File: doc/BRIEF.md
# Refresh Urgency Controller

This block tracks how many refresh intervals of one memory rank have passed without their refresh being issued, and turns that backlog into a refresh request with a two-bit urgency level. Each interval tick adds one owed refresh, and each refresh grant from the command arbiter removes one. While the backlog is small, the block asks for a refresh only when the rank has been quiet for a programmed number of clock cycles. This lets refreshes slip into idle gaps.

Two programmable backlog watermarks raise the urgency. At the first watermark the request becomes high priority, whatever the rank activity. At the second it becomes panic priority. With the urgent watermark programmed at 9 or more, the full allowed postponement can be used. Suitable settings are 8 for high, 9 for panic and 63 cycles for the idle period. Command arbitration, precharge sequencing and refresh command timing are left to neighbouring blocks.

Top module: `refresh_urgency_ctl`

## Requirements
- R1: After reset, req_o is 0, prio_o is 00, the backlog is zero and the idle count is zero.
- R2: A cycle with tick_i high and grant_i low adds one to the backlog.
- R3: The backlog saturates at 15. Further ticks leave it at 15.
- R4: A cycle with grant_i high and tick_i low removes one from the backlog. A grant while the backlog is zero has no effect.
- R5: A cycle with tick_i and grant_i both high leaves the backlog unchanged.
- R6: The idle count returns to zero after any cycle with busy_i high. It rises by one after each cycle with busy_i low, saturating at 255. The idle period is reached when the count is at least idle_lim_i.
- R7: prio_o is 01 (opportunistic) when the backlog is non-zero, below high_wm_i and below panic_wm_i, and the idle period is reached.
- R8: prio_o is 10 (high) when the backlog is non-zero, at or above high_wm_i and below panic_wm_i, whatever busy_i does.
- R9: prio_o is 11 (panic) when the backlog is non-zero and at or above panic_wm_i. Panic wins even if high_wm_i is larger.
- R10: req_o is 1 exactly when prio_o is non-zero. A grant that empties the backlog makes both read 0 after that clock edge.
- R11: With a zero backlog, prio_o is 00 whatever the watermarks, including zero, and whatever the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per elapsed refresh interval |
| busy_i | input | 1 | Rank has activity this cycle |
| grant_i | input | 1 | A refresh was issued to the rank this cycle |
| high_wm_i | input | 4 | Backlog level that selects high priority |
| panic_wm_i | input | 4 | Backlog level that selects panic priority |
| idle_lim_i | input | 8 | Quiet cycles needed for an opportunistic refresh |
| req_o | output | 1 | Refresh wanted |
| prio_o | output | 2 | 00 none, 01 opportunistic, 10 high, 11 panic |

## Verification
An interval tick and a refresh grant can arrive on the same cycle. Both then act on the backlog register. The bench drives them together while the backlog sits exactly on the high watermark. It then checks that the priority stays high. A single grant that follows must drop the priority with the rank kept busy, which shows that the backlog neither grew nor shrank.

// File: rtl/refresh_urgency_pkg.sv
package refresh_urgency_pkg;
  typedef enum logic [1:0] {
    PRIO_NONE  = 2'b00,
    PRIO_OPP   = 2'b01,
    PRIO_HIGH  = 2'b10,
    PRIO_PANIC = 2'b11
  } prio_e;
endpackage

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             grant_i,
  output logic [CNT_W-1:0] backlog_o
);
  localparam logic [CNT_W-1:0] BL_MAX = '1;

  logic [CNT_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      case ({tick_i, grant_i})
        2'b10:   if (q != BL_MAX) q <= q + 1'b1;
        2'b01:   if (q != '0)     q <= q - 1'b1;
        default: q <= q; // tick and grant cancel
      endcase
    end
  end

  assign backlog_o = q;
endmodule

// File: rtl/rfsh_idle_timer.sv
module rfsh_idle_timer #(
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [IDLE_W-1:0] idle_lim_i,
  output logic [IDLE_W-1:0] idle_cnt_o,
  output logic              idle_ok_o
);
  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic [IDLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (busy_i) begin
      cnt_q <= '0;
    end else if (cnt_q != IDLE_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idle_cnt_o = cnt_q;
  assign idle_ok_o  = (cnt_q >= idle_lim_i);
endmodule

// File: rtl/rfsh_prio_enc.sv
module rfsh_prio_enc
  import refresh_urgency_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic [CNT_W-1:0] backlog_i,
  input  logic [CNT_W-1:0] high_wm_i,
  input  logic [CNT_W-1:0] panic_wm_i,
  input  logic             idle_ok_i,
  output prio_e            prio_o
);
  logic owed;
  assign owed = (backlog_i != '0);

  always_comb begin
    prio_o = PRIO_NONE;
    if (owed) begin
      if (backlog_i >= panic_wm_i)     prio_o = PRIO_PANIC;
      else if (backlog_i >= high_wm_i) prio_o = PRIO_HIGH;
      else if (idle_ok_i)              prio_o = PRIO_OPP;
    end
  end
endmodule

// File: rtl/refresh_urgency_ctl.sv
module refresh_urgency_ctl
  import refresh_urgency_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              busy_i,
  input  logic              grant_i,
  input  logic [CNT_W-1:0]  high_wm_i,
  input  logic [CNT_W-1:0]  panic_wm_i,
  input  logic [IDLE_W-1:0] idle_lim_i,
  output logic              req_o,
  output logic [1:0]        prio_o
);
  logic [CNT_W-1:0]  backlog_q;
  logic [IDLE_W-1:0] idle_cnt_q;
  logic              idle_ok;
  prio_e             prio;

  rfsh_backlog #(.CNT_W(CNT_W)) u_backlog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .grant_i   (grant_i),
    .backlog_o (backlog_q)
  );

  rfsh_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy_i),
    .idle_lim_i (idle_lim_i),
    .idle_cnt_o (idle_cnt_q),
    .idle_ok_o  (idle_ok)
  );

  rfsh_prio_enc #(.CNT_W(CNT_W)) u_enc (
    .backlog_i  (backlog_q),
    .high_wm_i  (high_wm_i),
    .panic_wm_i (panic_wm_i),
    .idle_ok_i  (idle_ok),
    .prio_o     (prio)
  );

  assign prio_o = prio;
  assign req_o  = (prio != PRIO_NONE);
endmodule

// File: rtl/refresh_urgency_chk.sv
module refresh_urgency_chk #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned IDLE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              busy_i,
  input logic              grant_i,
  input logic [CNT_W-1:0]  high_wm_i,
  input logic [CNT_W-1:0]  panic_wm_i,
  input logic              req_o,
  input logic [1:0]        prio_o,
  input logic [CNT_W-1:0]  backlog,
  input logic [IDLE_W-1:0] idle_cnt
);
  localparam logic [CNT_W-1:0] BL_MAX = '1;

  a_r2_tick_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !grant_i && backlog != BL_MAX) |=> backlog == $past(backlog) + 1'b1);

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backlog == BL_MAX && !grant_i) |=> backlog == BL_MAX);

  a_r4_grant_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && !tick_i && backlog != '0) |=> backlog == $past(backlog) - 1'b1);

  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && !tick_i && backlog == '0) |=> backlog == '0);

  a_r5_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && grant_i) |=> $stable(backlog));

  a_r6_idle_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> idle_cnt == '0);

  a_r9_panic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backlog != '0 && backlog >= panic_wm_i) |-> prio_o == 2'b11);

  a_r10_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o == (prio_o != 2'b00));

  a_r11_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backlog == '0) |-> !req_o);
endmodule

bind refresh_urgency_ctl refresh_urgency_chk #(.CNT_W(CNT_W), .IDLE_W(IDLE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .busy_i     (busy_i),
  .grant_i    (grant_i),
  .high_wm_i  (high_wm_i),
  .panic_wm_i (panic_wm_i),
  .req_o      (req_o),
  .prio_o     (prio_o),
  .backlog    (backlog_q),
  .idle_cnt   (idle_cnt_q)
);

// File: tb/sim_refresh_urgency_ctl.sv
module sim_refresh_urgency_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0, busy = 1'b0, grant = 1'b0;
  logic [3:0] high_wm = 4'd8, panic_wm = 4'd9;
  logic [7:0] idle_lim = 8'd63;
  logic       req;
  logic [1:0] prio;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_urgency_ctl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .busy_i(busy), .grant_i(grant),
    .high_wm_i(high_wm), .panic_wm_i(panic_wm), .idle_lim_i(idle_lim),
    .req_o(req), .prio_o(prio)
  );

  task automatic chk(input string rq, input logic [1:0] ep);
    checks++;
    if (prio !== ep || req !== (ep != 2'b00)) begin
      errors++;
      $display("FAIL %s: prio=%b req=%b expected prio=%b req=%b", rq, prio, req, ep, ep != 2'b00);
    end
  endtask

  // apply inputs for one cycle, return 1 time unit after the edge
  task automatic cyc(input logic t, input logic b, input logic g);
    tick = t; busy = b; grant = g;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    tick = 0; busy = 1; grant = 0;
    high_wm = 4'd8; panic_wm = 4'd9; idle_lim = 8'd63;
    rst_ni = 0;
    @(posedge clk); #1;
    rst_ni = 1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset", 2'b00);
    idle_lim = 8'd0; #1;
    chk("R1 empty backlog after reset", 2'b00);
  endtask

  task automatic t_count();
    do_reset();
    high_wm = 4'd3;
    cyc(1, 1, 0); cyc(1, 1, 0);
    chk("R2 two ticks below high", 2'b00);
    cyc(1, 1, 0);
    chk("R8 three ticks reach high", 2'b10);
    cyc(0, 1, 1);
    chk("R4 grant drops below high", 2'b00);
  endtask

  task automatic t_saturate();
    do_reset();
    high_wm = 4'd15; panic_wm = 4'd15;
    for (int i = 0; i < 20; i++) cyc(1, 1, 0);
    chk("R3 backlog held at 15", 2'b11);
    cyc(0, 1, 1);
    chk("R3 one grant from 15 leaves 14", 2'b00);
  endtask

  task automatic t_grant_empty();
    do_reset();
    cyc(0, 1, 1);
    high_wm = 4'd1; #1;
    chk("R4 grant at zero ignored", 2'b00);
    cyc(1, 1, 0);
    chk("R4 single tick after ignored grant", 2'b10);
  endtask

  task automatic t_collide();
    do_reset();
    high_wm = 4'd2;
    cyc(1, 1, 0); cyc(1, 1, 0);
    chk("R8 backlog 2 high", 2'b10);
    cyc(1, 1, 1);
    chk("R5 tick and grant together", 2'b10);
    cyc(0, 1, 1);
    chk("R5 one grant after collision", 2'b00);
  endtask

  task automatic t_idle();
    do_reset();
    idle_lim = 8'd5;
    cyc(1, 1, 0);
    chk("R6 busy blocks opportunity", 2'b00);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0);
    chk("R6 four idle cycles not enough", 2'b00);
    cyc(0, 0, 0);
    chk("R7 five idle cycles", 2'b01);
    cyc(0, 1, 0);
    chk("R6 busy restarts timer", 2'b00);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0);
    chk("R7 opportunity again", 2'b01);
    cyc(0, 0, 1);
    chk("R10 grant empties backlog", 2'b00);
  endtask

  task automatic t_levels();
    do_reset();
    high_wm = 4'd3; panic_wm = 4'd2;
    cyc(1, 1, 0);
    chk("R7 busy backlog 1 none", 2'b00);
    cyc(1, 1, 0);
    chk("R9 panic precedes high", 2'b11);
    high_wm = 4'd8; panic_wm = 4'd9; idle_lim = 8'd0; #1;
    chk("R7 zero idle limit", 2'b01);
  endtask

  task automatic t_zero_wm();
    do_reset();
    high_wm = 4'd0; panic_wm = 4'd0; idle_lim = 8'd0;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0);
    chk("R11 zero watermarks empty backlog", 2'b00);
    cyc(1, 0, 0);
    chk("R9 zero panic watermark with backlog", 2'b11);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_saturate();
    t_grant_empty();
    t_collide();
    t_idle();
    t_levels();
    t_zero_wm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule